// File: doc/BRIEF.md
# Write-Cycle Status Readback

This block forms the word a host sees on the data bus of a parallel non-volatile memory while the memory runs an internal programming cycle. When no cycle is in progress, a read passes the array data straight through. While a cycle is running, the top three bits of the read word carry status instead of data:

- The most significant bit returns the inverse of the same bit of the last byte written.
- The next bit alternates on each finished read.
- The third bit reports whether the page load timer has expired.

The remaining lower bits are left undriven. The block also produces a per-bit drive mask for the tri-state pad ring. Control of the programming cycle and write protection are handled elsewhere.

Chip-enable and output-enable are active low and are sampled on `clk`. A read access lasts as long as both are low. It ends on the first clock edge at which either of them is seen high.

Top module: `wcs_readback`

## Requirements
- R1: With `prog_busy` low and both enables low, `dq_out` equals `array_rd_data` and every bit of `dq_drive` is 1.
- R2: Whenever `ce_n` or `oe_n` is high, `dq_drive` is all zeros and `dq_out` is all zeros.
- R3: With `prog_busy` high and both enables low, bit DW-1 of `dq_out` is the inverse of bit DW-1 of `last_wr_data`.
- R4: After `prog_busy` rises, the first read shows 0 on bit DW-2. Each read access that ends while `prog_busy` is high inverts the bit seen on the next read, giving 0,1,0,1,...
- R5: The bit DW-2 state changes only when a read ends during a programming cycle. Holding a read open, or finishing reads while not busy, leaves it unchanged.
- R6: With `prog_busy` high and both enables low, bit DW-3 of `dq_out` is 0 while `load_tmr_run` is 1 and 1 while it is 0.
- R7: With `prog_busy` high and both enables low, `dq_drive` has 1 only in the three top bit positions (0xE0 for DW=8). The undriven lower bits of `dq_out` read 0.
- R8: Once `prog_busy` falls, a read returns `array_rd_data` unmodified, including the true value of bit DW-1.
- R9: After reset, the toggle state is 0, so the first status read with no preceding busy edge shows 0 on bit DW-2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| prog_busy | input | 1 | High while the internal programming cycle runs |
| load_tmr_run | input | 1 | High while the page load timer is running |
| last_wr_data | input | DW | Last byte latched for programming |
| array_rd_data | input | DW | Array data at the current read address |
| dq_out | output | DW | Read word toward the pads |
| dq_drive | output | DW | Per-bit output drive enable |

## Verification
The bench builds the block with its default data width of 8. This places the status bits at positions 7, 6 and 5 and the expected drive mask at 0xE0. At that width, every status bit and every undriven bit is visible on the ports. The bench can therefore compare whole words and masks against values it computes itself, across idle reads, busy reads and the transitions between them.

// File: rtl/wcs_pkg.sv
// Shared definitions for the write-cycle status readback logic.
// Assumes the status field occupies the top bits of the data word.
package wcs_pkg;
    // Offsets of the status bits counted down from the most significant bit.
    localparam int POLL_OFS    = 0;
    localparam int TOGGLE_OFS  = 1;
    localparam int TIMER_OFS   = 2;
    localparam int STATUS_BITS = 3;

    // Source selected for the read word.
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_ARRAY  = 2'd1,
        SRC_STATUS = 2'd2
    } rd_src_e;
endpackage

// File: rtl/wcs_access_track.sv
// Tracks read accesses: decodes the active-low enables into a read-active
// flag and flags the cycle in which an access ends. Also flags the first
// cycle of a programming cycle. Assumes the enables are synchronous to clk.
module wcs_access_track (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic busy,
    output logic rd_active,
    output logic rd_end,
    output logic busy_rise
);
    logic rd_active_q;
    logic busy_q;

    assign rd_active = ~ce_n & ~oe_n;
    assign rd_end    = rd_active_q & ~rd_active;
    assign busy_rise = busy & ~busy_q;

    // Remember last cycle's read and busy state for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_active_q <= 1'b0;
            busy_q      <= 1'b0;
        end else begin
            rd_active_q <= rd_active;
            busy_q      <= busy;
        end
    end

    // R4
    read_end_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_active |=> (rd_end == !rd_active));
endmodule

// File: rtl/wcs_toggle.sv
// Holds the alternating status bit. It clears at the start of each
// programming cycle and inverts after every read that ends while busy.
// Assumes busy_rise and rd_end are single-cycle strobes.
module wcs_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic busy_rise,
    input  logic rd_end,
    output logic tog
);
    // Clear on a new cycle; otherwise advance on completed busy reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tog <= 1'b0;
        else if (busy_rise)
            tog <= 1'b0;
        else if (busy && rd_end)
            tog <= ~tog;
    end

    // R4
    tog_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_rise |=> (tog == 1'b0));
    // R4
    tog_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_end && !busy_rise) |=> (tog != $past(tog)));
    // R5
    tog_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(tog));
    // R5
    tog_hold_noend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_end && !busy_rise) |=> $stable(tog));
endmodule

// File: rtl/wcs_word_mux.sv
// Builds the read word and the drive mask from the selected source.
// Assumes DW >= STATUS_BITS + 1, so at least one bit is undriven in status.
module wcs_word_mux
    import wcs_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          rd_active,
    input  logic          busy,
    input  logic          tog,
    input  logic          tmr_run,
    input  logic [DW-1:0] last_wr,
    input  logic [DW-1:0] arr_data,
    output logic [DW-1:0] word,
    output logic [DW-1:0] drive
);
    localparam int POLL_BIT   = DW - 1 - POLL_OFS;
    localparam int TOGGLE_BIT = DW - 1 - TOGGLE_OFS;
    localparam int TIMER_BIT  = DW - 1 - TIMER_OFS;
    localparam int LOW_BITS   = DW - STATUS_BITS;

    rd_src_e       src;
    logic [DW-1:0] status_word;
    logic [DW-1:0] status_mask;

    // Pick the source of the read word.
    always_comb begin
        if (!rd_active)
            src = SRC_NONE;
        else if (busy)
            src = SRC_STATUS;
        else
            src = SRC_ARRAY;
    end

    // Place each status bit at its position; low bits stay zero and undriven.
    generate
        for (genvar i = 0; i < DW; i++) begin : g_bit
            if (i == POLL_BIT) begin : g_poll
                assign status_word[i] = ~last_wr[i];
                assign status_mask[i] = 1'b1;
            end else if (i == TOGGLE_BIT) begin : g_tog
                assign status_word[i] = tog;
                assign status_mask[i] = 1'b1;
            end else if (i == TIMER_BIT) begin : g_tmr
                assign status_word[i] = ~tmr_run;
                assign status_mask[i] = 1'b1;
            end else begin : g_low
                assign status_word[i] = 1'b0;
                assign status_mask[i] = 1'b0;
            end
        end
    endgenerate

    // Steer word and mask from the chosen source.
    always_comb begin
        unique case (src)
            SRC_ARRAY: begin
                word  = arr_data;
                drive = '1;
            end
            SRC_STATUS: begin
                word  = status_word;
                drive = status_mask;
            end
            default: begin
                word  = '0;
                drive = '0;
            end
        endcase
    end

    // R7
    low_undriven_chk: assert final (!(rd_active && busy) || (drive[LOW_BITS-1:0] == '0));
endmodule

// File: rtl/wcs_readback.sv
// Top of the write-cycle status readback logic. Returns array data when
// idle and a status word during programming, with a tri-state drive mask.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module wcs_readback #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          prog_busy,
    input  logic          load_tmr_run,
    input  logic [DW-1:0] last_wr_data,
    input  logic [DW-1:0] array_rd_data,
    output logic [DW-1:0] dq_out,
    output logic [DW-1:0] dq_drive
);
    logic rd_active;
    logic rd_end;
    logic busy_rise;
    logic tog;

    wcs_access_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .busy      (prog_busy),
        .rd_active (rd_active),
        .rd_end    (rd_end),
        .busy_rise (busy_rise)
    );

    wcs_toggle u_tog (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (prog_busy),
        .busy_rise (busy_rise),
        .rd_end    (rd_end),
        .tog       (tog)
    );

    wcs_word_mux #(.DW(DW)) u_mux (
        .rd_active (rd_active),
        .busy      (prog_busy),
        .tog       (tog),
        .tmr_run   (load_tmr_run),
        .last_wr   (last_wr_data),
        .arr_data  (array_rd_data),
        .word      (dq_out),
        .drive     (dq_drive)
    );

    // R2
    no_drive_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |-> (dq_drive == '0));
    // R1
    idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !prog_busy) |-> (dq_out == array_rd_data && dq_drive == '1));
    // R3
    poll_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && prog_busy) |-> (dq_out[DW-1] != last_wr_data[DW-1]));
    // R6
    timer_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && prog_busy) |-> (dq_out[DW-3] == !load_tmr_run));
    // R7
    status_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && prog_busy) |-> ($countones(dq_drive) == 3));
endmodule

// File: tb/wcs_readback_tb.sv
module wcs_readback_tb;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          prog_busy = 1'b0;
    logic          load_tmr_run = 1'b0;
    logic [DW-1:0] last_wr_data = '0;
    logic [DW-1:0] array_rd_data = '0;
    logic [DW-1:0] dq_out;
    logic [DW-1:0] dq_drive;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    wcs_readback #(.DW(DW)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ce_n          (ce_n),
        .oe_n          (oe_n),
        .prog_busy     (prog_busy),
        .load_tmr_run  (load_tmr_run),
        .last_wr_data  (last_wr_data),
        .array_rd_data (array_rd_data),
        .dq_out        (dq_out),
        .dq_drive      (dq_drive)
    );

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Open a read, sample mid-cycle, then close it (toggle updates at next edge).
    task automatic do_read(output logic [DW-1:0] d, output logic [DW-1:0] m);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        #1; d = dq_out; m = dq_drive;
        oe_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1;
    endtask

    task automatic start_busy();
        @(negedge clk);
        prog_busy = 1'b1;
        cyc(2);
    endtask

    task automatic t_reset();
        logic [DW-1:0] d, m;
        #1;
        check("R2", dq_drive, 8'h00, "mask after reset, enables high");
        last_wr_data = 8'h00; load_tmr_run = 1'b1;
        start_busy();
        do_read(d, m);
        check("R9", {7'd0, d[6]}, 8'd0, "toggle bit first read after reset");
        prog_busy = 1'b0; cyc(2);
    endtask

    task automatic t_idle_read();
        logic [DW-1:0] d, m;
        array_rd_data = 8'h5A;
        do_read(d, m);
        check("R1", d, 8'h5A, "idle data");
        check("R1", m, 8'hFF, "idle mask");
        array_rd_data = 8'hA3;
        do_read(d, m);
        check("R1", d, 8'hA3, "idle data 2");
    endtask

    task automatic t_disabled();
        @(negedge clk);
        array_rd_data = 8'hFF;
        ce_n = 1'b0; oe_n = 1'b1; #1;
        check("R2", dq_drive, 8'h00, "oe high mask");
        check("R2", dq_out, 8'h00, "oe high data");
        ce_n = 1'b1; oe_n = 1'b0; #1;
        check("R2", dq_drive, 8'h00, "ce high mask");
        prog_busy = 1'b1; #1;
        check("R2", dq_drive, 8'h00, "ce high busy mask");
        oe_n = 1'b1; prog_busy = 1'b0;
        cyc(2);
    endtask

    task automatic t_status();
        logic [DW-1:0] d, m;
        last_wr_data = 8'h80; load_tmr_run = 1'b1; array_rd_data = 8'hFF;
        start_busy();
        do_read(d, m);
        check("R3", {7'd0, d[7]}, 8'd0, "poll bit of 0x80");
        check("R6", {7'd0, d[5]}, 8'd0, "timer running");
        check("R7", m, 8'hE0, "status mask");
        check("R7", {3'd0, d[4:0]}, 8'd0, "low bits");
        last_wr_data = 8'h35; load_tmr_run = 1'b0;
        do_read(d, m);
        check("R3", {7'd0, d[7]}, 8'd1, "poll bit of 0x35");
        check("R6", {7'd0, d[5]}, 8'd1, "timer expired");
        @(negedge clk); prog_busy = 1'b0; cyc(2);
    endtask

    task automatic t_toggle();
        logic [DW-1:0] d, m;
        start_busy();
        for (int i = 0; i < 5; i++) begin
            do_read(d, m);
            check("R4", {7'd0, d[6]}, {7'd0, 1'(i % 2)}, "toggle sequence");
        end
        // Hold a read open: toggle does not move.
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
        cyc(4); #1;
        check("R5", {7'd0, dq_out[6]}, 8'd1, "toggle held during long read");
        cyc(3); #1;
        check("R5", {7'd0, dq_out[6]}, 8'd1, "toggle still held");
        ce_n = 1'b1; oe_n = 1'b1;
        cyc(1);
        // New cycle after idle reads: restarts at 0.
        prog_busy = 1'b0; cyc(2);
        do_read(d, m); do_read(d, m); do_read(d, m);
        start_busy();
        do_read(d, m);
        check("R4", {7'd0, d[6]}, 8'd0, "first read of new cycle");
        // Ending a read via ce_n also advances.
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); ce_n = 1'b1;
        @(negedge clk); oe_n = 1'b1;
        do_read(d, m);
        check("R4", {7'd0, d[6]}, 8'd0, "advance after ce-ended read");
        @(negedge clk); prog_busy = 1'b0; cyc(2);
    endtask

    task automatic t_busy_end();
        logic [DW-1:0] d, m;
        last_wr_data = 8'h9C; array_rd_data = 8'h9C;
        start_busy();
        do_read(d, m);
        check("R3", {7'd0, d[7]}, 8'd0, "poll inverse of 0x9C");
        @(negedge clk); prog_busy = 1'b0;
        do_read(d, m);
        check("R8", d, 8'h9C, "true data after cycle");
        check("R8", m, 8'hFF, "full mask after cycle");
        // Toggle held while idle: an idle-only read sequence with busy low.
        do_read(d, m);
        check("R5", d, 8'h9C, "idle read unaffected");
    endtask

    initial begin
        cyc(3);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_idle_read();
        t_disabled();
        t_status();
        t_toggle();
        t_busy_end();
        done = 1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule